// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block is a register-mapped bank of independent pulse-width modulators. Each channel counts raw input clock cycles with no prescaler and drives one output pin. Software sets the pulse length, the cycle length, a pulse budget and a small control word through a single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Each channel keeps the values software writes in shadow storage. The running waveform uses a separate active copy of the cycle and pulse lengths. Setting the start bit on an idle channel loads the active copy at once. Writing a 1 to the start bit while the channel is already running asks for a reload, and the reload happens at the next cycle boundary. The running waveform therefore never shows a half-updated setting. A channel either runs without end or emits a set number of cycles and then clears its own start bit.

Top module: `pwm_bank`

## Requirements
- R1: The byte address selects the channel in bits [ADDR_W-1:5], so each channel has a 32-byte window. The word offset within the window selects the cycle length (0x0), the pulse length (0x4), the cycle budget (0x8) or the control word (0xC).
- R2: The cycle length, pulse length and budget registers read back the full 32-bit value last written. The control word reads back bit 0 (start), bit 1 (invert) and bit 2 (free-run), with all higher bits zero. Each write replaces all three control bits, so any one bit can be changed by writing the others back unchanged.
- R3: An address with bit 4 set or with bits [1:0] non-zero is unmapped. It reads as zero, and a write to it changes no register.
- R4: With invert at 0, the output is high while the cycle counter is below the active pulse length and low for the rest of a cycle of the active cycle length.
- R5: A pulse length of 0 gives a constant low output. A pulse length equal to or above the cycle length gives a constant high output.
- R6: Invert at 1 inverts the output. A stopped channel drives its inactive level, which equals the invert bit.
- R7: Cycle or pulse length values written while the channel runs do not change the output until a 1 is written to start again. After that write, the new values take effect from the next cycle boundary.
- R8: Writing start=1 to a stopped channel loads the shadow values. The counter then starts at 0 in the cycle after the write.
- R9: With free-run at 0, the channel emits max(budget,1) full cycles and then clears its start bit. Software can read the cleared bit.
- R10: With free-run at 1, the channel keeps running without limit.
- R11: An active cycle length of 0 holds the output at its inactive level.
- R12: Writing start=0 stops the channel at once. The output goes to the inactive level in the same cycle as the write, and the counter returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address: channel in the upper bits, word offset in [4:0] |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
The checker watches four things on every cycle: the inactive level of stopped channels and of channels with a zero cycle length, the zero read of unmapped addresses, the capture of control writes, and the self-clearing of the start bit when the budget runs out. The following behaviours only the bench scenarios can show, by comparing each output cycle with a behavioural model: the shape of the waveform, the deferred reload at the cycle boundary, the exact number of cycles in budget mode, and the extreme pulse lengths.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   // log2 of the per-channel register window in bytes
   localparam int WIN_LOG2 = 5;

   // word offsets within a channel window (address bits [3:2])
   localparam logic [1:0] W_PER  = 2'd0;
   localparam logic [1:0] W_DUTY = 2'd1;
   localparam logic [1:0] W_LIM  = 2'd2;
   localparam logic [1:0] W_CTRL = 2'd3;

   // control word bit positions
   localparam int CTL_EN   = 0;
   localparam int CTL_POL  = 1;
   localparam int CTL_KEEP = 2;

   typedef struct packed {
      logic keep;
      logic pol;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [1:0]        word_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done,
   output logic [DATA_W-1:0] per_sh,
   output logic [DATA_W-1:0] duty_sh,
   output logic [DATA_W-1:0] lim,
   output logic              en,
   output logic              pol,
   output logic              keep,
   output logic              arm,
   output logic              ctrl_wr,
   output logic [DATA_W-1:0] rd_data
);
   ctrl_t ctrl_q;

   assign ctrl_wr = wr_hit && (word_sel == W_CTRL);
   assign arm     = ctrl_wr && wdata[CTL_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh  <= '0;
         duty_sh <= '0;
         lim     <= '0;
         ctrl_q  <= '0;
      end else begin
         if (wr_hit && word_sel == W_PER)  per_sh  <= wdata;
         if (wr_hit && word_sel == W_DUTY) duty_sh <= wdata;
         if (wr_hit && word_sel == W_LIM)  lim     <= wdata;
         if (ctrl_wr) begin
            ctrl_q.en   <= wdata[CTL_EN];
            ctrl_q.pol  <= wdata[CTL_POL];
            ctrl_q.keep <= wdata[CTL_KEEP];
         end else if (done) begin
            ctrl_q.en <= 1'b0;   // budget exhausted: self-clear (R9)
         end
      end
   end

   assign en   = ctrl_q.en;
   assign pol  = ctrl_q.pol;
   assign keep = ctrl_q.keep;

   always_comb begin
      unique case (word_sel)
         W_PER:   rd_data = per_sh;
         W_DUTY:  rd_data = duty_sh;
         W_LIM:   rd_data = lim;
         default: rd_data = DATA_W'(ctrl_q);
      endcase
   end
endmodule

// File: rtl/pwm_bank_core.sv
module pwm_bank_core #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pol,
   input  logic              keep,
   input  logic              arm,
   input  logic [DATA_W-1:0] per_sh,
   input  logic [DATA_W-1:0] duty_sh,
   input  logic [DATA_W-1:0] lim,
   output logic              pwm,
   output logic              done,
   output logic              per_zero
);
   logic [DATA_W-1:0] act_per, act_duty, cnt, emitted;
   logic              pend;
   logic [DATA_W:0]   emit_next;
   logic              boundary, arm_idle, arm_run;

   assign per_zero  = (act_per == '0);
   assign boundary  = per_zero || (cnt == act_per - DATA_W'(1));
   assign arm_idle  = arm && !en;
   assign arm_run   = arm && en;
   assign emit_next = {1'b0, emitted} + (DATA_W+1)'(1);
   assign done      = en && boundary && !per_zero && !keep &&
                      (emit_next >= {1'b0, lim});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_per  <= '0;
         act_duty <= '0;
         cnt      <= '0;
         emitted  <= '0;
         pend     <= 1'b0;
      end else if (arm_idle) begin
         act_per  <= per_sh;     // R8: start from fresh shadow values
         act_duty <= duty_sh;
         cnt      <= '0;
         emitted  <= '0;
         pend     <= 1'b0;
      end else if (!en) begin
         cnt      <= '0;
         emitted  <= '0;
         pend     <= 1'b0;
      end else begin
         if (boundary) begin
            cnt <= '0;
            if (pend) begin      // R7: deferred reload at cycle boundary
               act_per  <= per_sh;
               act_duty <= duty_sh;
               emitted  <= '0;
            end else if (!per_zero) begin
               emitted <= emit_next[DATA_W-1:0];
            end
         end else begin
            cnt <= cnt + DATA_W'(1);
         end
         if (arm_run)       pend <= 1'b1;
         else if (boundary) pend <= 1'b0;
      end
   end

   assign pwm = (en && !per_zero) ? ((cnt < act_duty) ^ pol) : pol;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int  NCH    = 4,
   parameter int  DATA_W = 32,
   localparam int CH_W   = $clog2(NCH),
   localparam int ADDR_W = WIN_LOG2 + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NCH-1:0]    pwm_out
);
   if (!(NCH == 2 || NCH == 4 || NCH == 8)) begin : g_bad_nch
      $error("pwm_bank: NCH must be 2, 4 or 8");
   end
   if (DATA_W < 3) begin : g_bad_width
      $error("pwm_bank: DATA_W must hold the control bits");
   end

   logic [CH_W-1:0]   ch_sel;
   logic [1:0]        word_sel;
   logic              in_map;
   logic [DATA_W-1:0] ch_rd [NCH];
   logic [NCH-1:0]    ch_en, ch_pol, ch_keep, ch_arm;
   logic [NCH-1:0]    ch_done, ch_per_zero, ch_ctrl_wr;

   assign ch_sel   = reg_addr[ADDR_W-1:WIN_LOG2];
   assign word_sel = reg_addr[3:2];
   assign in_map   = (reg_addr[4] == 1'b0) && (reg_addr[1:0] == 2'b00);  // R3

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic              hit;
      logic [DATA_W-1:0] per_sh, duty_sh, lim;

      assign hit = reg_we && in_map && (ch_sel == CH_W'(i));

      pwm_bank_regs #(.DATA_W(DATA_W)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (hit),
         .word_sel (word_sel),
         .wdata    (reg_wdata),
         .done     (ch_done[i]),
         .per_sh   (per_sh),
         .duty_sh  (duty_sh),
         .lim      (lim),
         .en       (ch_en[i]),
         .pol      (ch_pol[i]),
         .keep     (ch_keep[i]),
         .arm      (ch_arm[i]),
         .ctrl_wr  (ch_ctrl_wr[i]),
         .rd_data  (ch_rd[i])
      );

      pwm_bank_core #(.DATA_W(DATA_W)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (ch_en[i]),
         .pol      (ch_pol[i]),
         .keep     (ch_keep[i]),
         .arm      (ch_arm[i]),
         .per_sh   (per_sh),
         .duty_sh  (duty_sh),
         .lim      (lim),
         .pwm      (pwm_out[i]),
         .done     (ch_done[i]),
         .per_zero (ch_per_zero[i])
      );
   end

   assign reg_rdata = in_map ? ch_rd[ch_sel] : '0;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int NCH    = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        addr_lo,
   input logic [2:0]        wdata_lo,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NCH-1:0]    pwm_out,
   input logic [NCH-1:0]    ch_en,
   input logic [NCH-1:0]    ch_pol,
   input logic [NCH-1:0]    ch_done,
   input logic [NCH-1:0]    ch_per_zero,
   input logic [NCH-1:0]    ch_ctrl_wr
);
   a_r3_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr_lo & 5'b10011) != 5'b00000) |-> (reg_rdata == '0));

   for (genvar i = 0; i < NCH; i++) begin : g_a
      a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |-> (pwm_out[i] == ch_pol[i]));

      a_r11_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_en[i] && ch_per_zero[i]) |-> (pwm_out[i] == ch_pol[i]));

      a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_done[i] && !ch_ctrl_wr[i]) |=> !ch_en[i]);

      a_r2_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
         ch_ctrl_wr[i] |=> (ch_en[i] == $past(wdata_lo[0])) &&
                           (ch_pol[i] == $past(wdata_lo[1])));
   end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_lo     (reg_addr[4:0]),
   .wdata_lo    (reg_wdata[2:0]),
   .reg_rdata   (reg_rdata),
   .pwm_out     (pwm_out),
   .ch_en       (ch_en),
   .ch_pol      (ch_pol),
   .ch_done     (ch_done),
   .ch_per_zero (ch_per_zero),
   .ch_ctrl_wr  (ch_ctrl_wr)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
   localparam int NCH = 4;
   localparam int AW  = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NCH-1:0] pout;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   pwm_bank #(.NCH(NCH), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
      .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pout)
   );

   // ---------------- behavioural reference model ----------------
   int unsigned m_per[NCH], m_duty[NCH], m_lim[NCH];
   int unsigned m_aper[NCH], m_aduty[NCH], m_cnt[NCH], m_emit[NCH];
   bit          m_en[NCH], m_pol[NCH], m_keep[NCH], m_pend[NCH];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_per[i] = 0; m_duty[i] = 0; m_lim[i] = 0; m_aper[i] = 0;
            m_aduty[i] = 0; m_cnt[i] = 0; m_emit[i] = 0;
            m_en[i] = 0; m_pol[i] = 0; m_keep[i] = 0; m_pend[i] = 0;
         end
      end else begin
         for (int i = 0; i < NCH; i++) begin
            bit sel, cw, arm, pz, bnd, dn;
            sel = we && (int'(addr[6:5]) == i) && !addr[4] && (addr[1:0] == 2'b00);
            cw  = sel && (addr[3:2] == 2'd3);
            arm = cw && wdata[0];
            pz  = (m_aper[i] == 0);
            bnd = pz || (m_cnt[i] == m_aper[i] - 1);
            dn  = m_en[i] && bnd && !pz && !m_keep[i] &&
                  (longint'(m_emit[i]) + 1 >= longint'(m_lim[i]));
            if (arm && !m_en[i]) begin
               m_aper[i] = m_per[i]; m_aduty[i] = m_duty[i];
               m_cnt[i] = 0; m_pend[i] = 0; m_emit[i] = 0;
            end else if (!m_en[i]) begin
               m_cnt[i] = 0; m_pend[i] = 0; m_emit[i] = 0;
            end else begin
               if (bnd) begin
                  m_cnt[i] = 0;
                  if (m_pend[i]) begin
                     m_aper[i] = m_per[i]; m_aduty[i] = m_duty[i]; m_emit[i] = 0;
                  end else if (!pz) m_emit[i]++;
               end else m_cnt[i]++;
               if (arm) m_pend[i] = 1;
               else if (bnd) m_pend[i] = 0;
            end
            if (sel && addr[3:2] == 2'd0) m_per[i]  = wdata;
            if (sel && addr[3:2] == 2'd1) m_duty[i] = wdata;
            if (sel && addr[3:2] == 2'd2) m_lim[i]  = wdata;
            if (cw) begin
               m_en[i] = wdata[0]; m_pol[i] = wdata[1]; m_keep[i] = wdata[2];
            end else if (dn) m_en[i] = 0;
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
      int c;
      c = int'(a[6:5]);
      if (a[4] || a[1:0] != 2'b00) return 32'h0;
      case (a[3:2])
         2'd0: return m_per[c];
         2'd1: return m_duty[c];
         2'd2: return m_lim[c];
         default: return {29'h0, m_keep[c], m_pol[c], m_en[c]};
      endcase
   endfunction

   // per-clock comparison against the model
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            logic e;
            e = (m_en[i] && m_aper[i] != 0) ? ((m_cnt[i] < m_aduty[i]) ^ m_pol[i]) : m_pol[i];
            nchk++;
            if (pout[i] !== e) begin
               nerr++;
               $display("FAIL R4 model ch%0d out act=%b exp=%b t=%0t", i, pout[i], e, $time);
            end
         end
         nchk++;
         if (rdata !== exp_rd(addr)) begin
            nerr++;
            $display("FAIL R2 model rdata act=%h exp=%h addr=%h", rdata, exp_rd(addr), addr);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
      @(negedge clk);
      addr = a;
      #1;
      check(tag, 64'(rdata), 64'(e));
   endtask

   // sample one channel on n consecutive cycles, starting now
   task automatic grab(int ch, int n, output logic [63:0] v);
      v = '0;
      for (int k = 0; k < n; k++) begin
         #1 v[k] = pout[ch];
         @(negedge clk);
      end
   endtask

   function automatic int ones(logic [63:0] v);
      return $countones(v);
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [63:0] v;
      logic [63:0] ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state: outputs at inactive level 0 (R6), registers clear (R2)
      check("R6 reset outputs", 64'(pout), 64'h0);
      rd(7'h0C, 32'h0, "R2 reset ctrl");
      rd(7'h00, 32'h0, "R2 reset period");

      // R1 / R2: window decode and full-width readback
      wr(7'h40, 32'hDEADBEEF);
      wr(7'h24, 32'h12345678);
      wr(7'h68, 32'h00A5_5A00);
      wr(7'h64, 32'hCAFE0001);
      rd(7'h40, 32'hDEADBEEF, "R2 ch2 period");
      rd(7'h24, 32'h12345678, "R1 ch1 duty");
      rd(7'h68, 32'h00A55A00, "R1 ch3 budget");
      rd(7'h64, 32'hCAFE0001, "R1 ch3 duty window");
      rd(7'h04, 32'h0, "R1 ch0 duty untouched");
      wr(7'h0C, 32'h2);
      wr(7'h0C, 32'h6);
      rd(7'h0C, 32'h6, "R2 ctrl bits");
      wr(7'h0C, 32'hFFFF_FFF8);
      rd(7'h0C, 32'h0, "R2 ctrl upper bits read zero");

      // R3: unmapped offsets
      wr(7'h00, 32'd5);
      wr(7'h10, 32'hFFFFFFFF);
      wr(7'h01, 32'hFFFFFFFF);
      wr(7'h1C, 32'h7);
      rd(7'h10, 32'h0, "R3 unmapped read 0x10");
      rd(7'h03, 32'h0, "R3 unmapped read 0x03");
      rd(7'h00, 32'd5, "R3 misaligned write ignored");
      rd(7'h0C, 32'h0, "R3 ctrl untouched");
      check("R3 outputs idle", 64'(pout), 64'h0);

      // R4 / R8: ch0 period 5 duty 2, free-run, start
      wr(7'h04, 32'd2);
      wr(7'h0C, 32'h5);
      grab(0, 10, v);
      for (int k = 0; k < 10; k++) ex[k] = ((k % 5) < 2);
      check("R8 first cycle high", 64'(v[0]), 64'h1);
      check("R4 waveform d2/p5", v & 64'h3FF, ex & 64'h3FF);

      // R7: new duty held in shadow until start re-written
      wr(7'h04, 32'd4);
      grab(0, 10, v);
      check("R7 duty unchanged before re-arm", 64'(ones(v)), 64'd4);
      wr(7'h0C, 32'h5);
      grab(0, 6, v);
      grab(0, 10, v);
      check("R7 duty applied after re-arm", 64'(ones(v)), 64'd8);
      rd(7'h0C, 32'h5, "R7 ctrl still running");

      // R10: free-run keeps going
      grab(0, 50, v);
      check("R10 free-run long window", 64'(ones(v)), 64'd40);

      // R12: start=0 stops immediately
      wr(7'h0C, 32'h4);
      grab(0, 5, v);
      check("R12 stop output low", v & 64'h1F, 64'h0);
      rd(7'h0C, 32'h4, "R12 ctrl readback");

      // R5: duty 0 -> low, duty == period -> high
      wr(7'h20, 32'd4);
      wr(7'h24, 32'd0);
      wr(7'h2C, 32'h5);
      grab(1, 8, v);
      check("R5 duty zero low", v & 64'hFF, 64'h0);
      wr(7'h40, 32'd4);
      wr(7'h44, 32'd4);
      wr(7'h4C, 32'h5);
      grab(2, 8, v);
      check("R5 duty equal period high", v & 64'hFF, 64'hFF);

      // R9: counted mode, budget 2 then budget 0
      wr(7'h2C, 32'h0);
      wr(7'h20, 32'd3);
      wr(7'h24, 32'd1);
      wr(7'h28, 32'd2);
      wr(7'h2C, 32'h1);
      grab(1, 10, v);
      check("R9 two cycles emitted", v & 64'h3FF, 64'h009);
      rd(7'h2C, 32'h0, "R9 start self-cleared");
      wr(7'h28, 32'd0);
      wr(7'h2C, 32'h1);
      grab(1, 8, v);
      check("R9 zero budget one cycle", 64'(ones(v)), 64'd1);
      rd(7'h2C, 32'h0, "R9 start self-cleared budget 0");

      // R6: invert, stopped and running
      wr(7'h6C, 32'h2);
      grab(3, 4, v);
      check("R6 stopped inverted level", v & 64'hF, 64'hF);
      wr(7'h60, 32'd4);
      wr(7'h64, 32'd1);
      wr(7'h6C, 32'h7);
      grab(3, 8, v);
      check("R6 inverted waveform", v & 64'hFF, 64'hEE);

      // R11: zero period holds inactive level
      wr(7'h6C, 32'h0);
      wr(7'h60, 32'd0);
      wr(7'h64, 32'd5);
      wr(7'h6C, 32'h5);
      grab(3, 8, v);
      check("R11 zero period low", v & 64'hFF, 64'h0);
      wr(7'h6C, 32'h7);
      grab(3, 4, v);
      check("R11 zero period inverted", v & 64'hF, 64'hF);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule